// File: doc/BRIEF.md
# Manchester II Framed Serial Encoder

This block takes a serial bit stream from an external shift register and sends it on a two-wire, active-low bipolar line as Manchester II framed words. Every word opens with a sync character lasting three bit periods, which is either a command sync or a data sync. K data bits follow, most significant bit first, and one parity bit closes the word. K is set by a 5-bit length code and can be any value from 2 to 28. Sync type, parity sense and length are all taken when a word starts, so each word can use different settings.

The whole block runs on one system clock `clk`. A prescaler, selected by a parameter, produces one half-bit tick every `PRESCALE_DIV` clocks. With the default of 6, a 12x bit-rate clock gives the bit rate. With a divide of 1, `clk` is itself the twice-bit-rate send clock. The block drives a shift clock out to the data source. The data request output `data_req_o` works as the ready side of the input stream, but the stream has no valid signal and no back-pressure. While `data_req_o` is high, the source must have the next bit on `ser_i` by the falling edge of `shift_clk_o`. The block takes that bit at the following rising edge, whether or not it is valid. The block itself never stalls: if enable stays high, words follow one another with no gap.

Top module: `manch_framer`

## Requirements
- R1: A word lasts K+4 bit periods, where K = `len_code_i` - 3. The length code is taken at the period boundary that starts the word. After the last period, the line returns to idle (both outputs high) unless a new word starts.
- R2: A length code below 5 is treated as 5, which gives K = 2.
- R3: Line level "positive" means `line_pos_n_o`=0 and `line_neg_n_o`=1. "Negative" is the reverse. A command sync (`cmd_sync_i`=1 at the start boundary) is positive for the first three half-bits and negative for the next three. A data sync is the inverse.
- R4: Data bits go out MSB first. A one is positive in its first half and negative in its second. A zero is the reverse. The bit sent in period p+1 is the `ser_i` value taken at the rising edge of `shift_clk_o` that ends period p.
- R5: `data_req_o` is high for exactly K periods. These are periods 2 through K+1, counted from 0 at the first sync period, so each requested bit is transmitted in the period after its request.
- R6: One parity bit follows the data. With `odd_par_i`=1 at the start boundary, the data bits plus the parity bit contain an odd number of ones. With `odd_par_i`=0, they contain an even number.
- R7: If `enable_i` is high at the boundary that ends the parity period, the next word's sync starts right away with no idle half-bit.
- R8: If `enable_i` is low at every period boundary while idle, no word starts, both line outputs stay high and `data_req_o` stays low.
- R9: While `inhibit_n_i` is low, both line outputs are high. Framing, `data_req_o` and data sampling carry on unchanged.
- R10: While `rst` is high at a clock edge, any word in progress is dropped. After release, the line is idle, `data_req_o` is low, `shift_clk_o` is high, and the next word starts normally.
- R11: While a word is in progress and not inhibited, exactly one line output is low.
- R12: `shift_clk_o` is high in the first half of each bit period and low in the second half. Each half lasts `PRESCALE_DIV` clocks, which is six with the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock: 12x bit rate with the default prescaler |
| rst | input | 1 | Synchronous master reset, active high |
| enable_i | input | 1 | Start or continue words, sampled at bit period boundaries |
| cmd_sync_i | input | 1 | 1 selects command sync, 0 selects data sync |
| odd_par_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| len_code_i | input | 5 | Word length code, K+3 |
| ser_i | input | 1 | Serial data from the external source |
| inhibit_n_i | input | 1 | Active low; forces both line outputs high |
| data_req_o | output | 1 | Request for the next serial bit |
| shift_clk_o | output | 1 | Bit-rate shift clock for the data source |
| line_pos_n_o | output | 1 | Active-low positive line drive |
| line_neg_n_o | output | 1 | Active-low negative line drive |

## Verification
The block's busiest moment is the period boundary that ends a parity bit. In that one tick it emits the last parity half, samples `enable_i`, latches the next word's sync type, parity sense and length code, and starts the new sync. The bench provokes this by holding enable through the word and changing all three settings during the parity period. It then compares every half-bit of both words against levels worked out from the requirements, with no idle half allowed between them. A second overlap is inhibit running during a word that chains into an uninhibited one. Here the outputs must stay high while the request count and the following word show that framing never paused.

// File: rtl/manch_pkg.sv
package manch_pkg;
  localparam int CODE_W   = 5;
  localparam logic [CODE_W-1:0] MIN_CODE = CODE_W'(5);

  // length codes below the shortest legal word are promoted to it
  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c);
    return (c < MIN_CODE) ? MIN_CODE : c;
  endfunction

  // line polarity during the three sync periods (1 = positive)
  function automatic logic sync_level(input logic cmd,
                                      input logic [CODE_W-1:0] per,
                                      input logic half);
    logic early;
    early = (per == '0) || (per == CODE_W'(1) && !half);
    return cmd ? early : ~early;
  endfunction
endpackage

// File: rtl/manch_prescale.sv
module manch_prescale #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] TOP = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (cnt == TOP) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == TOP);
    end
  endgenerate
endmodule

// File: rtl/manch_seq.sv
module manch_seq
  import manch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              enable_i,
  input  logic              cmd_sync_i,
  input  logic              odd_par_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              ser_i,
  output logic              half_o,
  output logic              req_o,
  output logic              busy_o,
  output logic              pos_o
);
  logic              half, busy, cmd_q, odd_q, bit_q, par_q;
  logic [CODE_W-1:0] per, last_q;
  logic              in_req, at_end;

  assign in_req = busy && (per >= CODE_W'(2)) && (per <= last_q - CODE_W'(2));
  assign at_end = !busy || (per == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      half   <= 1'b0;
      busy   <= 1'b0;
      cmd_q  <= 1'b0;
      odd_q  <= 1'b0;
      bit_q  <= 1'b0;
      par_q  <= 1'b0;
      per    <= '0;
      last_q <= MIN_CODE;
    end else if (tick) begin
      half <= ~half;
      if (half) begin
        if (in_req) begin
          bit_q <= ser_i;
          par_q <= par_q ^ ser_i;
        end
        if (at_end) begin
          busy <= enable_i;
          per  <= '0;
          if (enable_i) begin
            cmd_q  <= cmd_sync_i;
            odd_q  <= odd_par_i;
            last_q <= clamp_code(len_code_i);
            par_q  <= 1'b0;
          end
        end else begin
          per <= per + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (per < CODE_W'(3))   pos_o = sync_level(cmd_q, per, half);
    else if (per == last_q) pos_o = par_q ^ odd_q ^ half;
    else                    pos_o = bit_q ^ half;
  end

  assign half_o = half;
  assign req_o  = in_req;
  assign busy_o = busy;
endmodule

// File: rtl/manch_drive.sv
module manch_drive (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic pos,
  output logic pos_n_q,
  output logic neg_n_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_n_q <= 1'b1;
      neg_n_q <= 1'b1;
    end else begin
      pos_n_q <= !(active && pos);
      neg_n_q <= !(active && !pos);
    end
  end
endmodule

// File: rtl/manch_framer.sv
module manch_framer
  import manch_pkg::*;
#(
  parameter int PRESCALE_DIV = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic              cmd_sync_i,
  input  logic              odd_par_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              ser_i,
  input  logic              inhibit_n_i,
  output logic              data_req_o,
  output logic              shift_clk_o,
  output logic              line_pos_n_o,
  output logic              line_neg_n_o
);
  logic tick, half, busy, pos;
  logic drv_pos_n, drv_neg_n;

  manch_prescale #(.DIV(PRESCALE_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick(tick)
  );

  manch_seq u_seq (
    .clk(clk), .rst(rst), .tick(tick),
    .enable_i(enable_i), .cmd_sync_i(cmd_sync_i), .odd_par_i(odd_par_i),
    .len_code_i(len_code_i), .ser_i(ser_i),
    .half_o(half), .req_o(data_req_o), .busy_o(busy), .pos_o(pos)
  );

  manch_drive u_drv (
    .clk(clk), .rst(rst), .active(busy), .pos(pos),
    .pos_n_q(drv_pos_n), .neg_n_q(drv_neg_n)
  );

  assign shift_clk_o  = ~half;
  assign line_pos_n_o = drv_pos_n | ~inhibit_n_i;
  assign line_neg_n_o = drv_neg_n | ~inhibit_n_i;
endmodule

// File: rtl/manch_framer_chk.sv
module manch_framer_chk #(
  parameter int DIV = 6
) (
  input logic clk,
  input logic rst,
  input logic inhibit_n,
  input logic shift_clk,
  input logic req,
  input logic pos_n,
  input logic neg_n,
  input logic drv_pos_n,
  input logic drv_neg_n
);
  localparam int CW = $clog2(DIV + 2);
  logic          sc_q, sc_chg_q, rst_d;
  logic [CW-1:0] hcnt;
  logic          sc_chg;

  assign sc_chg = (shift_clk != sc_q);

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      sc_q     <= 1'b1;
      sc_chg_q <= 1'b0;
      hcnt     <= '0;
    end else begin
      sc_q     <= shift_clk;
      sc_chg_q <= sc_chg;
      hcnt     <= sc_chg ? CW'(1) : hcnt + 1'b1;
    end
  end

  // R12: a shift clock half lasts exactly DIV clocks
  p_half_len_r12: assert property (@(posedge clk) disable iff (rst)
    sc_chg |-> (hcnt == CW'(DIV)))
    else $error("p_half_len_r12");

  // R5: the request only moves on a half-bit tick
  p_req_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(req) |-> sc_chg)
    else $error("p_req_aligned_r5");

  // R4: line drive registers move only the clock after a half-bit tick
  p_line_on_half_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable({drv_pos_n, drv_neg_n}) |-> sc_chg_q)
    else $error("p_line_on_half_r4");

  // R10: first cycle after reset is idle
  p_reset_idle_r10: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (pos_n && neg_n && !req))
    else $error("p_reset_idle_r10");

  // R11: inside a word one line output is active
  p_req_line_r11: assert property (@(posedge clk) disable iff (rst)
    (req && $past(req) && inhibit_n) |-> (pos_n ^ neg_n))
    else $error("p_req_line_r11");
endmodule

bind manch_framer manch_framer_chk #(.DIV(PRESCALE_DIV)) u_chk (
  .clk(clk), .rst(rst), .inhibit_n(inhibit_n_i), .shift_clk(shift_clk_o),
  .req(data_req_o), .pos_n(line_pos_n_o), .neg_n(line_neg_n_o),
  .drv_pos_n(drv_pos_n), .drv_neg_n(drv_neg_n)
);

// File: tb/manch_framer_test.sv
module manch_framer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable_i = 1'b0, cmd_sync_i = 1'b0, odd_par_i = 1'b0;
  logic [4:0] len_code_i = 5'd5;
  logic       ser_i = 1'b0, inhibit_n_i = 1'b1;
  logic       data_req_o, shift_clk_o, line_pos_n_o, line_neg_n_o;
  int         n_cmp = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;  // 50 MHz

  manch_framer uut (
    .clk(clk), .rst(rst), .enable_i(enable_i), .cmd_sync_i(cmd_sync_i),
    .odd_par_i(odd_par_i), .len_code_i(len_code_i), .ser_i(ser_i),
    .inhibit_n_i(inhibit_n_i), .data_req_o(data_req_o), .shift_clk_o(shift_clk_o),
    .line_pos_n_o(line_pos_n_o), .line_neg_n_o(line_neg_n_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // step to 2.5 clocks after the next shift clock toggle
  task automatic next_half();
    logic prev;
    prev = shift_clk_o;
    @(negedge clk);
    while (shift_clk_o == prev) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic sync_low();
    do next_half(); while (shift_clk_o != 1'b0);
  endtask

  // called inside a low shift clock half, block idle or in its last period
  task automatic run_frame(input logic cmd, input logic odd, input logic [4:0] code,
                           input logic [27:0] data, input logic keep_en, input logic inh);
    int   last, k;
    logic par, pos, b;
    string tag;
    last = (code < 5) ? 5 : int'(code);
    k    = last - 3;
    par  = odd;
    for (int i = 0; i < k; i++) par ^= data[i];
    enable_i = 1'b1; cmd_sync_i = cmd; odd_par_i = odd; len_code_i = code;
    inhibit_n_i = !inh;
    for (int p = 0; p <= last; p++) begin
      for (int h = 0; h < 2; h++) begin
        next_half();
        if (p < 3) begin
          b = (p == 0) || (p == 1 && h == 0);
          pos = cmd ? b : !b; tag = "R3";
        end else if (p == last) begin
          pos = par ^ h[0]; tag = "R6";
        end else begin
          pos = data[k - 1 - (p - 3)] ^ h[0]; tag = "R4";
        end
        if (inh) tag = "R9";
        chk(tag, "pos_n", int'(line_pos_n_o), inh ? 1 : int'(!pos));
        chk(tag, "neg_n", int'(line_neg_n_o), inh ? 1 : int'(pos));
        chk("R12", "shift_clk", int'(shift_clk_o), (h == 0) ? 1 : 0);
        if (h == 1) begin
          b = (p >= 2) && (p <= last - 2);
          chk("R5", "data_req", int'(data_req_o), int'(b));
          if (b) ser_i = data[k - 1 - (p - 2)];
          if (p == 0 && !keep_en) enable_i = 1'b0;
        end
      end
    end
    if (!keep_en) begin
      next_half();
      chk("R1", "idle pos_n after frame", int'(line_pos_n_o), 1);
      chk("R1", "idle neg_n after frame", int'(line_neg_n_o), 1);
    end
  endtask

  task automatic t_reset_state();
    chk("R10", "reset pos_n", int'(line_pos_n_o), 1);
    chk("R10", "reset neg_n", int'(line_neg_n_o), 1);
    chk("R10", "reset req", int'(data_req_o), 0);
    chk("R10", "reset shift_clk", int'(shift_clk_o), 1);
  endtask

  task automatic t_shift_clock();
    logic prev;
    int   n;
    next_half();
    for (int r = 0; r < 2; r++) begin
      prev = shift_clk_o; n = 0;
      do begin @(negedge clk); n++; end while (shift_clk_o == prev);
      if (r > 0) chk("R12", "half length", n, 6);
      else       chk("R12", "half length tail", int'(n <= 6), 1);
    end
  endtask

  task automatic t_enable_low();
    enable_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      next_half();
      chk("R8", "idle pos_n", int'(line_pos_n_o), 1);
      chk("R8", "idle neg_n", int'(line_neg_n_o), 1);
      chk("R8", "idle req", int'(data_req_o), 0);
    end
  endtask

  task automatic t_cmd_frame();
    sync_low();
    run_frame(1'b1, 1'b1, 5'd15, 28'h0000A5C, 1'b0, 1'b0);
  endtask

  task automatic t_short_data_frame();
    sync_low();
    run_frame(1'b0, 1'b0, 5'd5, 28'h0000002, 1'b0, 1'b0);
  endtask

  task automatic t_max_frame();
    sync_low();
    run_frame(1'b1, 1'b0, 5'd31, 28'hB3F0A96, 1'b0, 1'b0);
  endtask

  task automatic t_clamp_R2();
    sync_low();
    run_frame(1'b0, 1'b1, 5'd2, 28'h0000001, 1'b0, 1'b0);
  endtask

  task automatic t_back_to_back_R7();
    sync_low();
    run_frame(1'b0, 1'b1, 5'd9, 28'h000002D, 1'b1, 1'b0);
    run_frame(1'b1, 1'b0, 5'd12, 28'h00001C6, 1'b0, 1'b0);
  endtask

  task automatic t_inhibit_R9();
    sync_low();
    run_frame(1'b1, 1'b0, 5'd10, 28'h0000057, 1'b1, 1'b1);
    run_frame(1'b0, 1'b0, 5'd8, 28'h000001B, 1'b0, 1'b0);
  endtask

  task automatic t_reset_abort_R10();
    sync_low();
    enable_i = 1'b1; cmd_sync_i = 1'b1; len_code_i = 5'd15; ser_i = 1'b1;
    repeat (8) next_half();
    enable_i = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    for (int i = 0; i < 6; i++) begin
      next_half();
      chk("R10", "post-abort pos_n", int'(line_pos_n_o), 1);
      chk("R10", "post-abort req", int'(data_req_o), 0);
    end
    sync_low();
    run_frame(1'b0, 1'b1, 5'd6, 28'h0000005, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_shift_clock();
    t_enable_low();
    t_cmd_frame();
    t_short_data_frame();
    t_max_frame();
    t_clamp_R2();
    t_back_to_back_R7();
    t_inhibit_R9();
    t_reset_abort_R10();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule